// File: doc/BRIEF.md
# Trace Message Port Access Decoder

This block is the bus-slave front end of a software trace port. Every cycle it can take one access: an address offset, a read/write flag, a command code, byte enables, a flag saying whether a debugger or the application issued it, and write data. It checks the access and, one cycle later, returns a response. Protocol faults get an in-band error. Software mistakes get a silent valid response. These mistakes are writes or reads into unmapped space, reads of the trace window and writes for a disabled CPU source.

The lower half of the offset space is the trace window. It holds 256 channels. Each channel is split into four message regions: two CPU sources, each with a plain and a timestamped region. A valid write there pulses a message strobe carrying the channel, the source, the timestamp flag and the data.

The upper half holds two configuration registers:
- A lock register, opened by writing a key value.
- A per-CPU enable register, guarded by that lock against application writes.

Top module: `trace_port_decoder`

## Requirements
- R1: Each cycle with `req_valid` high yields exactly one cycle of `rsp_valid` high on the next cycle. A cycle without a request yields `rsp_valid` and `msg_valid` low on the next cycle.
- R2: The only supported command code is `req_cmd` = 2'b00 (single beat). Codes 2'b01, 2'b10 and 2'b11 return `rsp_err` high.
- R3: Any byte-enable pattern other than 4'b1111 returns `rsp_err` high.
- R4: An address with `req_addr[1:0]` not equal to 2'b00 returns `rsp_err` high.
- R5: A valid write with `req_addr[20]`=0 and the source enabled pulses `msg_valid` for one cycle, in the same cycle as its response. The pulse carries:
  - `msg_chan` = `req_addr[19:12]`;
  - `msg_cpu` = `req_addr[11]` (0 = CPU1, 1 = CPU2);
  - `msg_ts` = `req_addr[10]`;
  - `msg_data` = the write data.
- R6: A valid trace-window write whose source has its enable bit clear gets a valid response (`rsp_err` low) and no message.
- R7: A valid read of the trace window gets a valid response with `rsp_rdata` all zeros and no message.
- R8: With `req_addr[20]`=1, offset `req_addr[19:0]` = 0x00000 is the lock register and 0x00004 is the enable register. In the enable register, bit 0 enables CPU1 and bit 1 enables CPU2. Every other offset there is a hole. A hole gets a valid response, reads zero, and a write to it changes no register.
- R9: The lock register reads as bit 0 = 1 when locked, and is locked after reset. It accepts every valid write from either master: a write of 32'h5A17C0DE unlocks, and any other value locks.
- R10: An application write (`req_dbg`=0) to the enable register while locked returns `rsp_err` high and leaves the enable bits unchanged.
- R11: A debugger write (`req_dbg`=1) to the enable register updates it regardless of the lock.
- R12: Reads are never refused because of the lock. After reset the enable register reads 0.
- R13: An access that returns `rsp_err` produces no message, reads zero data and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dbg | input | 1 | 1 = issued by the debugger, 0 = by the application |
| req_cmd | input | 2 | Command code, 2'b00 = single beat |
| req_be | input | 4 | Byte enables |
| req_addr | input | 21 | Byte address offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | In-band error |
| rsp_rdata | output | 32 | Read data |
| msg_valid | output | 1 | Trace message strobe |
| msg_chan | output | 8 | Message channel |
| msg_cpu | output | 1 | Message source, 0 = CPU1, 1 = CPU2 |
| msg_ts | output | 1 | Message is timestamped |
| msg_data | output | 32 | Message payload |

## Verification
The assertions assume that `req_valid` stays low while reset is asserted. They also assume that every request field is driven to a known value whenever `req_valid` is high, since the response and the enable-register checks are sampled from those fields one cycle later. The stimulus holds `req_valid` low through reset and drives each access for exactly one cycle from the falling edge, with all fields defined. It lowers `req_valid` at the next falling edge.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    localparam int ADDR_W   = 21;
    localparam int DATA_W   = 32;
    localparam int CHAN_W   = 8;
    localparam int NUM_CPU  = 2;
    localparam int BE_W     = DATA_W / 8;
    localparam int ALIGN_W  = $clog2(BE_W);
    localparam int TYPE_LSB = 10;
    localparam int CHAN_LSB = TYPE_LSB + 2;
    localparam int OFS_W    = ADDR_W - 1;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h5A17_C0DE;
    localparam logic [OFS_W-1:0]  LOCK_OFS   = OFS_W'(0);
    localparam logic [OFS_W-1:0]  ENAB_OFS   = OFS_W'(4);

    typedef enum logic [1:0] {
        CMD_SINGLE = 2'b00,
        CMD_INCR   = 2'b01,
        CMD_WRAP   = 2'b10,
        CMD_RSVD   = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        TGT_TRACE,
        TGT_LOCK,
        TGT_ENAB,
        TGT_HOLE
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic              proto_err;
        logic [CHAN_W-1:0] chan;
        logic              cpu;
        logic              ts;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic              cpu;
        logic              ts;
        logic [DATA_W-1:0] data;
    } msg_t;

    function automatic tgt_e map_target(input logic [ADDR_W-1:0] a);
        if (!a[ADDR_W-1])                  return TGT_TRACE;
        else if (a[OFS_W-1:0] == LOCK_OFS) return TGT_LOCK;
        else if (a[OFS_W-1:0] == ENAB_OFS) return TGT_ENAB;
        else                               return TGT_HOLE;
    endfunction

endpackage

// File: rtl/tpd_decode.sv
module tpd_decode
    import tpd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  cmd_e              cmd,
    input  logic [BE_W-1:0]   be,
    output dec_t              dec
);

    logic bad_cmd;
    logic bad_be;
    logic bad_align;

    always_comb begin
        bad_cmd   = (cmd != CMD_SINGLE);
        bad_be    = (be != {BE_W{1'b1}});
        bad_align = (addr[ALIGN_W-1:0] != '0);

        dec.tgt       = map_target(addr);
        dec.proto_err = bad_cmd | bad_be | bad_align;
        dec.chan      = addr[CHAN_LSB +: CHAN_W];
        dec.cpu       = addr[TYPE_LSB+1];
        dec.ts        = addr[TYPE_LSB];
    end

endmodule

// File: rtl/tpd_cfg.sv
module tpd_cfg
    import tpd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_dbg,
    input  logic [DATA_W-1:0]  req_wdata,
    input  tgt_e               tgt,
    input  logic               proto_err,
    output logic               locked,
    output logic [NUM_CPU-1:0] enab,
    output logic               lock_fault,
    output logic [DATA_W-1:0]  cfg_rdata
);

    logic wr_ok;
    logic lock_we;
    logic enab_we;

    always_comb begin
        wr_ok      = req_valid & req_write & ~proto_err;
        lock_we    = wr_ok & (tgt == TGT_LOCK);
        lock_fault = wr_ok & (tgt == TGT_ENAB) & locked & ~req_dbg;
        enab_we    = wr_ok & (tgt == TGT_ENAB) & (~locked | req_dbg);
    end

    always_ff @(posedge clk) begin
        if (rst)          locked <= 1'b1;
        else if (lock_we) locked <= (req_wdata != UNLOCK_KEY);
    end

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_en
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)          bit_q <= 1'b0;
            else if (enab_we) bit_q <= req_wdata[i];
        end
        assign enab[i] = bit_q;
    end

    always_comb begin
        unique case (tgt)
            TGT_LOCK: cfg_rdata = {{(DATA_W-1){1'b0}}, locked};
            TGT_ENAB: cfg_rdata = {{(DATA_W-NUM_CPU){1'b0}}, enab};
            default:  cfg_rdata = '0;
        endcase
    end

    // R10: a refused application write leaves the enable bits alone
    p_locked_hold_r10: assert property (@(posedge clk) disable iff (rst)
        lock_fault |=> $stable(enab));

    // R9: the key opens the lock on the next cycle
    p_key_unlocks_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !proto_err && tgt == TGT_LOCK &&
         req_wdata == UNLOCK_KEY) |=> !locked);

    // R8: hole writes and reads touch no register
    p_hole_inert_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && tgt == TGT_HOLE) |=> ($stable(enab) && $stable(locked)));

    // R13: erroneous accesses change no register
    p_err_inert_r13: assert property (@(posedge clk) disable iff (rst)
        (req_valid && proto_err) |=> ($stable(enab) && $stable(locked)));

endmodule

// File: rtl/tpd_resp.sv
module tpd_resp
    import tpd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    input  dec_t               dec,
    input  logic               lock_fault,
    input  logic [DATA_W-1:0]  cfg_rdata,
    input  logic [NUM_CPU-1:0] enab,
    output rsp_t               rsp,
    output msg_t               msg
);

    logic              err_c;
    logic              fire_c;
    logic [DATA_W-1:0] rdata_c;

    always_comb begin
        err_c   = dec.proto_err | lock_fault;
        fire_c  = req_valid & req_write & ~err_c & (dec.tgt == TGT_TRACE)
                  & enab[dec.cpu];
        rdata_c = '0;
        if (!req_write && !err_c &&
            (dec.tgt == TGT_LOCK || dec.tgt == TGT_ENAB))
            rdata_c = cfg_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
            msg <= '0;
        end else begin
            rsp.valid <= req_valid;
            rsp.err   <= req_valid & err_c;
            rsp.rdata <= req_valid ? rdata_c : '0;
            msg.valid <= fire_c;
            if (fire_c) begin
                msg.chan <= dec.chan;
                msg.cpu  <= dec.cpu;
                msg.ts   <= dec.ts;
                msg.data <= req_wdata;
            end
        end
    end

    // R1: every request is answered on the following cycle, and only then
    p_resp_follow_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp.valid);
    p_resp_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp.valid && !msg.valid));

    // R5: a message only accompanies a clean response
    p_msg_clean_r5: assert property (@(posedge clk) disable iff (rst)
        msg.valid |-> (rsp.valid && !rsp.err));

    // R13: errors carry no message and no data
    p_err_zero_r13: assert property (@(posedge clk) disable iff (rst)
        rsp.err |-> (!msg.valid && rsp.rdata == '0));

    // R7: trace-window reads return zero
    p_trace_rd_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && dec.tgt == TGT_TRACE)
        |=> (rsp.rdata == '0 && !msg.valid));

endmodule

// File: rtl/trace_port_decoder.sv
module trace_port_decoder
    import tpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_dbg,
    input  logic [1:0]        req_cmd,
    input  logic [BE_W-1:0]   req_be,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              msg_valid,
    output logic [CHAN_W-1:0] msg_chan,
    output logic              msg_cpu,
    output logic              msg_ts,
    output logic [DATA_W-1:0] msg_data
);

    dec_t               dec;
    rsp_t               rsp;
    msg_t               msg;
    logic               locked;
    logic [NUM_CPU-1:0] enab;
    logic               lock_fault;
    logic [DATA_W-1:0]  cfg_rdata;

    tpd_decode u_decode (
        .addr (req_addr),
        .cmd  (cmd_e'(req_cmd)),
        .be   (req_be),
        .dec  (dec)
    );

    tpd_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_dbg    (req_dbg),
        .req_wdata  (req_wdata),
        .tgt        (dec.tgt),
        .proto_err  (dec.proto_err),
        .locked     (locked),
        .enab       (enab),
        .lock_fault (lock_fault),
        .cfg_rdata  (cfg_rdata)
    );

    tpd_resp u_resp (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .dec        (dec),
        .lock_fault (lock_fault),
        .cfg_rdata  (cfg_rdata),
        .enab       (enab),
        .rsp        (rsp),
        .msg        (msg)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_err   = rsp.err;
    assign rsp_rdata = rsp.rdata;
    assign msg_valid = msg.valid;
    assign msg_chan  = msg.chan;
    assign msg_cpu   = msg.cpu;
    assign msg_ts    = msg.ts;
    assign msg_data  = msg.data;

    // R11: a debugger write to the enable register is never refused
    p_dbg_never_locked_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_dbg && dec.tgt == TGT_ENAB &&
         req_cmd == 2'b00 && req_be == {BE_W{1'b1}} && req_addr[1:0] == 2'b00)
        |=> !rsp_err);

    // R12: reads are never refused for lock reasons
    p_read_unlocked_r12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !dec.proto_err) |=> !rsp_err);

endmodule

// File: tb/tb_trace_port_decoder.sv
module tb_trace_port_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_dbg = 1'b0;
    logic [1:0]  req_cmd = 2'b00;
    logic [3:0]  req_be = 4'hF;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, msg_valid, msg_cpu, msg_ts;
    logic [31:0] rsp_rdata, msg_data;
    logic [7:0]  msg_chan;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state
    bit       m_locked;
    bit [1:0] m_en;

    localparam logic [31:0] KEY = 32'h5A17_C0DE;
    localparam logic [20:0] CFG_LOCK = 21'h100000;
    localparam logic [20:0] CFG_EN   = 21'h100004;

    always #5 clk = ~clk;

    trace_port_decoder dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_dbg(req_dbg), .req_cmd(req_cmd), .req_be(req_be),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .msg_valid(msg_valid),
        .msg_chan(msg_chan), .msg_cpu(msg_cpu), .msg_ts(msg_ts),
        .msg_data(msg_data)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        @(negedge clk);
        chk(tag, "idle rsp_valid", 32'(rsp_valid), 0);
        chk(tag, "idle msg_valid", 32'(msg_valid), 0);
    endtask

    task automatic access(input string tag, input bit wr, input bit dbg,
                          input logic [1:0] cmd, input logic [3:0] be,
                          input logic [20:0] addr, input logic [31:0] wd);
        bit          e_err, e_msg, perr, is_cfg;
        logic [31:0] e_rd;
        logic [19:0] ofs;
        req_valid = 1'b1; req_write = wr; req_dbg = dbg; req_cmd = cmd;
        req_be = be; req_addr = addr; req_wdata = wd;
        // reference model
        perr   = (cmd != 2'b00) || (be != 4'hF) || (addr[1:0] != 2'b00);
        is_cfg = addr[20];
        ofs    = addr[19:0];
        e_err = perr;
        e_msg = 1'b0;
        e_rd  = 32'h0;
        if (!perr) begin
            if (!is_cfg) begin
                if (wr) e_msg = m_en[addr[11]];
            end else if (ofs == 20'h0) begin
                if (wr) m_locked = (wd != KEY);
                else    e_rd = {31'h0, m_locked};
            end else if (ofs == 20'h4) begin
                if (wr) begin
                    if (m_locked && !dbg) e_err = 1'b1;
                    else                  m_en = wd[1:0];
                end else e_rd = {30'h0, m_en};
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, "rsp_valid", 32'(rsp_valid), 1);
        chk(tag, "rsp_err",   32'(rsp_err), 32'(e_err));
        chk(tag, "rsp_rdata", rsp_rdata, e_rd);
        chk(tag, "msg_valid", 32'(msg_valid), 32'(e_msg));
        if (e_msg) begin
            chk(tag, "msg_chan", 32'(msg_chan), 32'(addr[19:12]));
            chk(tag, "msg_cpu",  32'(msg_cpu),  32'(addr[11]));
            chk(tag, "msg_ts",   32'(msg_ts),   32'(addr[10]));
            chk(tag, "msg_data", msg_data, wd);
        end
    endtask

    task automatic rd(input string tag, input logic [20:0] a);
        access(tag, 1'b0, 1'b0, 2'b00, 4'hF, a, 32'h0);
    endtask

    task automatic wr(input string tag, input bit dbg, input logic [20:0] a,
                      input logic [31:0] d);
        access(tag, 1'b1, dbg, 2'b00, 4'hF, a, d);
    endtask

    initial begin
        m_locked = 1'b1;
        m_en = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        idle("R1");
        rd("R9", CFG_LOCK);
        rd("R12", CFG_EN);

        // disabled sources
        wr("R6", 1'b0, 21'h00000, 32'h1111_0001);
        wr("R6", 1'b0, 21'h00C00, 32'h1111_0002);

        // locked application write, then debugger write
        wr("R10", 1'b0, CFG_EN, 32'h3);
        rd("R10", CFG_EN);
        wr("R11", 1'b1, CFG_EN, 32'h3);
        rd("R11", CFG_EN);
        rd("R12", CFG_LOCK);

        // trace writes over all four message types and corner channels
        wr("R5", 1'b0, 21'h00000, 32'hA000_0000);
        wr("R5", 1'b0, 21'h00404, 32'hA000_0001);
        wr("R5", 1'b0, 21'h1A000, 32'hA000_0026);
        wr("R5", 1'b0, 21'h86400, 32'hA000_0134);
        wr("R5", 1'b1, 21'h33800, 32'hA000_0051);
        wr("R5", 1'b0, 21'hFFC00, 32'hA000_0255);
        wr("R5", 1'b0, 21'hFFFFC, 32'hA000_FFFC);
        wr("R5", 1'b0, 21'hFF000, 32'hA000_F000);
        idle("R1");

        // trace reads
        rd("R7", 21'h00000);
        rd("R7", 21'hFFC08);

        // protocol errors
        access("R2", 1'b1, 1'b0, 2'b01, 4'hF, 21'h00000, 32'hE1);
        access("R2", 1'b1, 1'b0, 2'b10, 4'hF, 21'h00400, 32'hE2);
        access("R2", 1'b0, 1'b0, 2'b11, 4'hF, CFG_EN, 32'h0);
        access("R3", 1'b1, 1'b0, 2'b00, 4'h7, 21'h00800, 32'hE3);
        access("R3", 1'b0, 1'b0, 2'b00, 4'h0, CFG_LOCK, 32'h0);
        access("R4", 1'b1, 1'b0, 2'b00, 4'hF, 21'h00002, 32'hE4);
        access("R4", 1'b0, 1'b0, 2'b00, 4'hF, 21'h00801, 32'h0);
        access("R13", 1'b1, 1'b1, 2'b01, 4'hF, CFG_EN, 32'h0);
        access("R13", 1'b1, 1'b0, 2'b00, 4'h3, CFG_LOCK, KEY);
        rd("R13", CFG_EN);
        rd("R13", CFG_LOCK);

        // holes
        wr("R8", 1'b0, 21'h100008, 32'hFFFF_FFFF);
        wr("R8", 1'b1, 21'h1FFFFC, 32'h0);
        rd("R8", 21'h100008);
        rd("R8", 21'h180000);
        rd("R8", CFG_EN);
        rd("R8", CFG_LOCK);

        // unlock, application write, relock
        wr("R9", 1'b0, CFG_LOCK, KEY);
        rd("R9", CFG_LOCK);
        wr("R9", 1'b0, CFG_EN, 32'h1);
        rd("R9", CFG_EN);
        wr("R6", 1'b0, 21'h55800, 32'hB0B0_0002);
        wr("R5", 1'b0, 21'h55400, 32'hB0B0_0001);
        wr("R9", 1'b1, CFG_LOCK, 32'h1234_5678);
        rd("R9", CFG_LOCK);
        wr("R10", 1'b0, CFG_EN, 32'h2);
        rd("R12", CFG_EN);
        idle("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule